// File: doc/BRIEF.md
# Multi-Sender Inter-Processor Message Queue

This block is a hardware message queue that carries 32-bit words from several on-chip agents to one receiving processor. Each sender presents a word on its own write port. The word holds a payload in its upper bits and the sender's 6-bit identifier in bits [5:0]. A fixed-priority arbiter accepts one write per cycle. The fullness test and the enqueue happen together in that same cycle, so two senders can never both take the last free slot.

When a write is accepted while the queue is full, the word is discarded. The overflow flag bit whose index equals the word's identifier is then set and stays set. No completion interrupt exists. A sender finds out whether its word was delivered by reading its flag and, if it is set, clearing it with a write-one-to-clear mask. The 64 flags appear as two 32-bit halves.

The receiver sees the head entry on a read-through data port and pops it with a read strobe. While anything is stored, a level interrupt stays asserted. It drops by itself once the queue is drained. The occupancy count and the full and empty status are visible as outputs.

Top module: `ipc_mbox_fifo`

## Requirements
- R1: Accepted words are delivered in arrival order, all 32 bits intact including the identifier field, and up to 128 entries can be stored.
- R2: `rd_data` shows the head entry while the queue holds data and reads zero when it is empty; a read strobe on an empty queue changes nothing.
- R3: `count` gives the number of stored entries (0 to 128), `full` is high exactly at 128 and `empty` exactly at 0; a push and a pop in the same cycle leave `count` unchanged.
- R4: A granted write is dropped when the queue is full at the start of that cycle, even if a pop happens in the same cycle, and it sets overflow flag number `word[5:0]`.
- R5: Among simultaneous write requests, the lowest port index is granted via `wr_gnt` in the same cycle, at most one per cycle; a request that is not granted neither enqueues nor sets a flag.
- R6: `irq` is high exactly when `count` is non-zero.
- R7: Overflow flags are sticky; `ovf_lo` bit i is identifier i, `ovf_hi` bit i is identifier 32+i; a cycle with `ovf_clr_we` high clears the flags of the half chosen by `ovf_clr_hi` (0 low, 1 high) where `ovf_clr_mask` has ones.
- R8: When a new overflow sets a flag in the same cycle that a clear targets it, the flag ends up set.
- R9: After reset the queue is empty, `count` is 0, `irq` is low and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | NPORT | Write request, one per sender port |
| wr_data | input | NPORT*32 | Write words, port i in bits [32i+31:32i] |
| wr_gnt | output | NPORT | Port accepted this cycle (enqueued or dropped) |
| rd_en | input | 1 | Pop the head entry |
| rd_data | output | 32 | Head entry, zero when empty |
| ovf_clr_we | input | 1 | Apply the clear mask this cycle |
| ovf_clr_hi | input | 1 | Clear target: 0 low half, 1 high half |
| ovf_clr_mask | input | 32 | Ones clear the matching flags |
| ovf_lo | output | 32 | Overflow flags for identifiers 0 to 31 |
| ovf_hi | output | 32 | Overflow flags for identifiers 32 to 63 |
| irq | output | 1 | Data-pending interrupt |
| count | output | 8 | Stored entry count |
| full | output | 1 | Queue holds 128 entries |
| empty | output | 1 | Queue holds nothing |

## Verification
A corrupted pointer or count shows up at once as a wrong `count` or a wrong head word on `rd_data`, because the bench compares both against a reference queue in every cycle. A flag that is set or cleared wrongly is visible on `ovf_lo` or `ovf_hi` one edge after the cycle that caused it. The bench drives a directed fill past 128 entries, a set-and-clear collision and a drain to empty. A long random phase then mixes two competing senders, reads and clears, so that the queue crosses both the full and the empty boundary many times.

// File: rtl/ipc_mbox_fifo.sv
module ipc_mbox_fifo #(
  parameter int DEPTH = 128,
  parameter int DW    = 32,
  parameter int IDW   = 6,
  parameter int NPORT = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPORT-1:0]              wr_req,
  input  logic [NPORT*DW-1:0]           wr_data,
  output logic [NPORT-1:0]              wr_gnt,
  input  logic                          rd_en,
  output logic [DW-1:0]                 rd_data,
  input  logic                          ovf_clr_we,
  input  logic                          ovf_clr_hi,
  input  logic [(1<<IDW)/2-1:0]         ovf_clr_mask,
  output logic [(1<<IDW)/2-1:0]         ovf_lo,
  output logic [(1<<IDW)/2-1:0]         ovf_hi,
  output logic                          irq,
  output logic [$clog2(DEPTH):0]        count,
  output logic                          full,
  output logic                          empty
);
  localparam int AW    = $clog2(DEPTH);
  localparam int NFLAG = 1 << IDW;
  localparam int HALF  = NFLAG / 2;
  localparam int SW    = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      cnt;
  logic [NFLAG-1:0] flags, clr_vec, set_vec;
  logic [SW-1:0]    sel;
  logic             any;
  logic [DW-1:0]    win;
  logic             do_push, do_drop, do_pop;

  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int i = NPORT - 1; i >= 0; i--)
      if (wr_req[i]) begin
        sel = SW'(i);
        any = 1'b1;
      end
    wr_gnt = '0;
    if (any) wr_gnt[sel] = 1'b1;
  end

  assign win     = wr_data[sel*DW +: DW];
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = any && !full;
  assign do_drop = any && full;
  assign do_pop  = rd_en && !empty;

  assign rd_data = empty ? '0 : mem[rp];
  assign count   = cnt;
  assign irq     = !empty;

  always_ff @(posedge clk)
    if (do_push) mem[wp] <= win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  always_comb begin
    clr_vec = '0;
    if (ovf_clr_we) begin
      if (ovf_clr_hi) clr_vec[NFLAG-1:HALF] = ovf_clr_mask;
      else            clr_vec[HALF-1:0]     = ovf_clr_mask;
    end
    set_vec = '0;
    if (do_drop) set_vec[win[IDW-1:0]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_vec) | set_vec;
  end

  assign ovf_lo = flags[HALF-1:0];
  assign ovf_hi = flags[NFLAG-1:HALF];
endmodule

// File: rtl/ipc_mbox_fifo_chk.sv
module ipc_mbox_fifo_chk #(
  parameter int DEPTH = 128,
  parameter int DW    = 32,
  parameter int IDW   = 6,
  parameter int NPORT = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NPORT-1:0]       wr_req,
  input logic [NPORT-1:0]       wr_gnt,
  input logic                   rd_en,
  input logic [DW-1:0]          rd_data,
  input logic                   ovf_clr_we,
  input logic [(1<<IDW)/2-1:0]  ovf_lo,
  input logic                   irq,
  input logic [$clog2(DEPTH):0] count,
  input logic                   full,
  input logic                   empty
);
  a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(wr_gnt));
  a_r5_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n) (wr_gnt & ~wr_req) == '0);
  a_r5_grant_when_req: assert property (@(posedge clk) disable iff (!rst_n) (wr_req != '0) |-> (wr_gnt != '0));
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n) count <= ($clog2(DEPTH)+1)'(DEPTH));
  a_r4_no_growth_when_full: assert property (@(posedge clk) disable iff (!rst_n) full |=> count <= $past(count));
  a_r6_irq_tracks_count: assert property (@(posedge clk) disable iff (!rst_n) irq == (count != '0));
  a_r2_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n) empty |-> rd_data == '0);
  a_r2_empty_read_no_change: assert property (@(posedge clk) disable iff (!rst_n) (empty && rd_en && wr_req == '0) |=> count == '0);
  a_r7_sticky_low: assert property (@(posedge clk) disable iff (!rst_n) !ovf_clr_we |=> (ovf_lo & $past(ovf_lo)) == $past(ovf_lo));
endmodule

bind ipc_mbox_fifo ipc_mbox_fifo_chk #(.DEPTH(DEPTH), .DW(DW), .IDW(IDW), .NPORT(NPORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_gnt(wr_gnt), .rd_en(rd_en),
  .rd_data(rd_data), .ovf_clr_we(ovf_clr_we), .ovf_lo(ovf_lo), .irq(irq),
  .count(count), .full(full), .empty(empty)
);

// File: tb/ipc_mbox_fifo_test.sv
`timescale 1ns/1ps
module ipc_mbox_fifo_test;
  localparam int DEPTH = 128;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  wr_req = 0;
  logic [63:0] wr_data = 0;
  logic [1:0]  wr_gnt;
  logic        rd_en = 0;
  logic [31:0] rd_data;
  logic        ovf_clr_we = 0, ovf_clr_hi = 0;
  logic [31:0] ovf_clr_mask = 0;
  logic [31:0] ovf_lo, ovf_hi;
  logic        irq, full, empty;
  logic [7:0]  count;

  int checks = 0, fails = 0;
  logic [31:0] q[$];
  logic [63:0] mflags = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ipc_mbox_fifo uut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_gnt(logic [1:0] r);
    return r[0] ? 2'b01 : (r[1] ? 2'b10 : 2'b00);
  endfunction

  task automatic check_state();
    chk("R3 count", 64'(count), 64'(q.size()));
    chk("R3 full", 64'(full), 64'(q.size() == DEPTH));
    chk("R3 empty", 64'(empty), 64'(q.size() == 0));
    chk("R6 irq", 64'(irq), 64'(q.size() != 0));
    chk("R7 flags", {ovf_hi, ovf_lo}, mflags);
  endtask

  task automatic step(logic [1:0] r, logic [31:0] d0, logic [31:0] d1, logic rd,
                      logic cwe, logic chi, logic [31:0] cm);
    logic [1:0]  g;
    logic [31:0] w;
    int          n;
    wr_req = r; wr_data = {d1, d0}; rd_en = rd;
    ovf_clr_we = cwe; ovf_clr_hi = chi; ovf_clr_mask = cm;
    #1;
    g = exp_gnt(r);
    chk("R5 grant", 64'(wr_gnt), 64'(g));
    chk("R1 R2 head", 64'(rd_data), 64'(q.size() != 0 ? q[0] : 32'h0));
    @(posedge clk);
    n = q.size();
    w = g[0] ? d0 : d1;
    if (rd && n > 0) void'(q.pop_front());
    if (cwe) begin
      if (chi) mflags[63:32] &= ~cm;
      else     mflags[31:0]  &= ~cm;
    end
    if (g != 0) begin
      if (n < DEPTH) q.push_back(w);
      else mflags[w[5:0]] = 1'b1;
    end
    @(negedge clk);
    check_state();
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_state();
    chk("R9 reset count", 64'(count), 64'(0));
    chk("R9 reset flags", {ovf_hi, ovf_lo}, 64'h0);

    // R2: read on empty does nothing
    step(2'b00, 0, 0, 1, 0, 0, 0);

    // R1 R3 R5: fill with both ports competing
    for (int i = 0; i < DEPTH + 6; i++)
      step(2'b11, {26'(i), 6'(i % 64)}, {26'(i + 1000), 6'd40}, 0, 0, 0, 0);
    chk("R4 flag id", {ovf_hi, ovf_lo}, mflags);

    // R4: full plus same-cycle pop still drops, flag 17 set
    step(2'b10, 0, {26'h3ff, 6'd17}, 1, 0, 0, 0);
    step(2'b01, {26'h1, 6'd50}, 0, 0, 0, 0, 0);

    // R8: set and clear of id 50 and id 5 together
    step(2'b01, {26'h2, 6'd50}, 0, 0, 1, 1, 32'h1 << 18);
    step(2'b01, {26'h2, 6'd5}, 0, 0, 1, 0, 32'h20);
    chk("R8 set wins", 64'(ovf_lo[5]), 64'd1);

    // R7: clear halves
    step(2'b00, 0, 0, 0, 1, 0, 32'hffff_ffff);
    step(2'b00, 0, 0, 0, 1, 1, 32'h0000_0100);

    // drain to empty, with push and pop together partway
    for (int i = 0; i < DEPTH + 4; i++)
      step((i == 10) ? 2'b10 : 2'b00, 0, {26'h777, 6'd33}, 1, 0, 0, 0);
    chk("R6 irq drained", 64'(irq), 64'd0);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      logic [1:0]  r  = 2'($urandom_range(0, 3));
      logic        rd = ($urandom_range(0, 99) < ((i / 500) % 2 ? 70 : 35));
      logic        cw = ($urandom_range(0, 9) == 0);
      step(r, $urandom, $urandom, rd, cw, 1'($urandom), $urandom);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule